// File: doc/BRIEF.md
# Vector Memory Instruction Decoder

This block turns the fields of a vector load or store instruction into a decoded memory operation. It takes the direction, the width field with its extended-width bit, the addressing-mode field, the unit-stride sub-op field and the field count, together with the element width, register-group multiplier and vector length currently held in the vector type state. From these it produces an operation class, the element width and register-group multiplier to use, the field count, the effective length, the implied byte stride for unit-stride accesses, the index width and index multiplier for indexed accesses, and one illegal flag that covers every rejected encoding.

The register-group multiplier for the memory elements is worked out in eighths, as log2 of EMUL×8, by adding exponents. Any result below 1/8 or above 8 is rejected. Any encoding whose registers, counted over all fields, exceed eight is also rejected. Reading the scalar stride register and issuing memory accesses belong to neighbouring blocks.

Instructions enter on a valid/ready stream and results leave on a second one. With the default registered output, a result appears one cycle after it is accepted. It is held unchanged while the consumer keeps ready low. A new instruction is accepted in the same cycle that the held result drains, so the block keeps full throughput under a steady ready. When a result is stalled, back-pressure reaches the producer in the same cycle.

Top module: `vls_decoder`

## Requirements
- R1: The 4-bit width code is {mew, width}. The codes 0000, 0101, 0110, 0111 and 1000 select 8, 16, 32, 64 and 128-bit elements. These appear on `out_eew` as 0, 1, 2, 3 and 4 (log2 of bytes).
- R2: Width codes 0001 to 0100 and 1001 to 1111 raise `out_illegal`.
- R3: The EMUL code (log2 of EMUL×8, where 0 means 1/8, 3 means 1 and 6 means 8) equals eew code + LMUL code − vsew. A result outside 0..6 raises `out_illegal`.
- R4: `out_nfields` = nf + 1. If 2^(EMUL code) × `out_nfields` > 64, `out_illegal` is raised.
- R5: `in_vsew` uses 0..3 for 8..64-bit elements and `in_vlmul` uses 000, 001, 010, 011, 101, 110, 111 for LMUL 1, 2, 4, 8, 1/8, 1/4, 1/2 (LMUL code 3, 4, 5, 6, 0, 1, 2). A vsew of 4 or more, or a vlmul of 100, raises `out_illegal`.
- R6: The mop field selects the class. mop 10 gives class 1 (strided), mop 01 gives class 2 (indexed, unordered) and mop 11 gives class 3 (indexed, ordered). mop 00 is unit-stride.
- R7: For unit-stride accesses, umop 00000 gives class 0 (plain), 01000 gives class 4 (whole register), 01011 gives class 5 (byte mask) and 10000 gives class 6 (fault-only-first, loads only). Any other umop, and 10000 on a store, is illegal.
- R8: Class 0 reports `out_stride` = element bytes × `out_nfields`. Classes 0, 1, 2, 3 and 6 report `out_evl` = vl.
- R9: For class 4 the field count must be 1, 2, 4 or 8, and a store must use 8-bit elements. `out_evl` = fields × (VLEN/8) / element bytes.
- R10: Class 5 requires 8-bit elements, and `out_evl` = (vl + 7) / 8.
- R11: For classes 2 and 3, `out_eew` and `out_emul` come from vsew and the LMUL code, while `out_idx_eew` and `out_idx_emul` come from the instruction. A 128-bit index width is illegal.
- R12: A result is presented one cycle after acceptance. It stays stable while `out_valid` is high and `out_ready` is low. `in_ready` is high when the output stage is empty or draining.
- R13: In reset, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Decoder can accept |
| in_is_store | input | 1 | 1 = store, 0 = load |
| in_mew | input | 1 | Extended-width bit |
| in_width | input | 3 | Width field |
| in_mop | input | 2 | Addressing-mode field |
| in_umop | input | 5 | Unit-stride sub-op field |
| in_nf | input | 3 | Encoded field count minus one |
| in_vsew | input | 3 | Current element width code |
| in_vlmul | input | 3 | Current register-group multiplier code |
| in_vl | input | VL_W | Current vector length |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| out_class | output | 3 | Operation class |
| out_eew | output | 3 | Data element width code |
| out_emul | output | 3 | Data EMUL code |
| out_nfields | output | 4 | Field count |
| out_evl | output | VL_W | Effective length |
| out_stride | output | STRIDE_W | Unit-stride byte stride |
| out_idx_eew | output | 3 | Index width code |
| out_idx_emul | output | 3 | Index EMUL code |
| out_illegal | output | 1 | Encoding rejected |

## Verification
Two things can happen in the same cycle: a held result drains and the next instruction is accepted into the output stage. The bench drives back-to-back instructions while `out_ready` follows an irregular pattern of low cycles. This produces cycles where the stage is stalled, cycles where it is drained and refilled at the same edge, and cycles where it is idle. A scoreboard built from the requirements judges each result in order. A lost, duplicated or overwritten result shows up as a field mismatch or as a count left in the queue at the end.

// File: rtl/vls_dec_pkg.sv
package vls_dec_pkg;

  typedef enum logic [2:0] {
    OPC_UNIT      = 3'd0,
    OPC_STRIDED   = 3'd1,
    OPC_IDX_UNORD = 3'd2,
    OPC_IDX_ORD   = 3'd3,
    OPC_WHOLE     = 3'd4,
    OPC_MASK      = 3'd5,
    OPC_FOF       = 3'd6
  } op_class_e;

  localparam logic [2:0] EW_8     = 3'd0;
  localparam logic [2:0] EW_128   = 3'd4;
  localparam int         EMUL_TOP = 6;
  localparam int         REG_BUDGET_EIGHTHS = 64;

  localparam logic [4:0] UM_PLAIN = 5'b00000;
  localparam logic [4:0] UM_WHOLE = 5'b01000;
  localparam logic [4:0] UM_MASK  = 5'b01011;
  localparam logic [4:0] UM_FOF   = 5'b10000;

  // log2(LMUL*8) from the vtype multiplier encoding (100 handled elsewhere)
  function automatic logic [2:0] lmul_code(input logic [2:0] vlmul);
    return vlmul[2] ? (vlmul - 3'd5) : (vlmul + 3'd3);
  endfunction

endpackage

// File: rtl/vls_width_dec.sv
module vls_width_dec (
  input  logic       mew,
  input  logic [2:0] width,
  output logic [2:0] eew,
  output logic       bad
);
  always_comb begin
    eew = 3'd0;
    bad = 1'b0;
    case ({mew, width})
      4'b0000: eew = 3'd0;
      4'b0101: eew = 3'd1;
      4'b0110: eew = 3'd2;
      4'b0111: eew = 3'd3;
      4'b1000: eew = 3'd4;
      default: bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/vls_emul_calc.sv
module vls_emul_calc
  import vls_dec_pkg::*;
(
  input  logic [2:0] eew,
  input  logic [2:0] vsew,
  input  logic [2:0] vlmul,
  input  logic [2:0] nf,
  output logic [2:0] lmul_c,
  output logic [2:0] emul,
  output logic [3:0] nfields,
  output logic       bad
);
  logic signed [4:0] sum;
  logic [7:0]        emul8;
  logic [11:0]       footprint;
  logic              vt_bad, rng_bad, fp_bad;

  always_comb begin
    lmul_c    = lmul_code(vlmul);
    nfields   = {1'b0, nf} + 4'd1;
    sum       = $signed({2'b00, eew}) + $signed({2'b00, lmul_c}) - $signed({2'b00, vsew});
    emul      = sum[2:0];
    emul8     = 8'd1 << emul;
    footprint = 12'(emul8) * 12'(nfields);
    vt_bad    = vsew[2] | (vlmul == 3'b100);
    rng_bad   = (sum < 0) || (sum > 5'(EMUL_TOP));
    fp_bad    = footprint > 12'(REG_BUDGET_EIGHTHS);
    bad       = vt_bad | rng_bad | fp_bad;
  end
endmodule

// File: rtl/vls_class_dec.sv
module vls_class_dec
  import vls_dec_pkg::*;
#(
  parameter int VL_W     = 16,
  parameter int STRIDE_W = 8,
  parameter int VLENB    = 16
) (
  input  logic            is_store,
  input  logic [1:0]      mop,
  input  logic [4:0]      umop,
  input  logic [2:0]      eew,
  input  logic [2:0]      emul,
  input  logic [3:0]      nfields,
  input  logic [2:0]      lmul_c,
  input  logic [2:0]      vsew,
  input  logic [VL_W-1:0] vl,
  output logic [2:0]      cls,
  output logic [2:0]      o_eew,
  output logic [2:0]      o_emul,
  output logic [VL_W-1:0] evl,
  output logic [STRIDE_W-1:0] stride,
  output logic [2:0]      idx_eew,
  output logic [2:0]      idx_emul,
  output logic            bad
);
  logic           pow2;
  logic [31:0]    whole_len;
  logic [VL_W:0]  mask_len;

  always_comb begin
    pow2      = (nfields & (nfields - 4'd1)) == 4'd0;
    whole_len = (32'(nfields) * 32'(VLENB)) >> eew;
    mask_len  = ({1'b0, vl} + (VL_W+1)'(7)) >> 3;

    cls      = OPC_UNIT;
    o_eew    = eew;
    o_emul   = emul;
    evl      = vl;
    stride   = '0;
    idx_eew  = eew;
    idx_emul = emul;
    bad      = 1'b0;

    unique case (mop)
      2'b00: begin
        unique case (umop)
          UM_PLAIN: begin
            cls    = OPC_UNIT;
            stride = STRIDE_W'(32'(nfields) << eew);
          end
          UM_WHOLE: begin
            cls = OPC_WHOLE;
            evl = VL_W'(whole_len);
            if (!pow2 || (is_store && eew != EW_8)) bad = 1'b1;
          end
          UM_MASK: begin
            cls = OPC_MASK;
            evl = VL_W'(mask_len);
            if (eew != EW_8) bad = 1'b1;
          end
          UM_FOF: begin
            cls = OPC_FOF;
            if (is_store) bad = 1'b1;
          end
          default: bad = 1'b1;
        endcase
      end
      2'b10: cls = OPC_STRIDED;
      default: begin
        cls    = mop[1] ? OPC_IDX_ORD : OPC_IDX_UNORD;
        o_eew  = vsew;
        o_emul = lmul_c;
        if (eew == EW_128) bad = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/vls_decoder.sv
module vls_decoder
  import vls_dec_pkg::*;
#(
  parameter int VLEN    = 128,
  parameter int VL_W    = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic            in_is_store,
  input  logic            in_mew,
  input  logic [2:0]      in_width,
  input  logic [1:0]      in_mop,
  input  logic [4:0]      in_umop,
  input  logic [2:0]      in_nf,
  input  logic [2:0]      in_vsew,
  input  logic [2:0]      in_vlmul,
  input  logic [VL_W-1:0] in_vl,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [2:0]      out_class,
  output logic [2:0]      out_eew,
  output logic [2:0]      out_emul,
  output logic [3:0]      out_nfields,
  output logic [VL_W-1:0] out_evl,
  output logic [$clog2(VLEN+1)-1:0] out_stride,
  output logic [2:0]      out_idx_eew,
  output logic [2:0]      out_idx_emul,
  output logic            out_illegal
);
  localparam int VLENB    = VLEN / 8;
  localparam int STRIDE_W = $clog2(VLEN + 1);

  logic [2:0] w_eew, c_lmul, c_emul;
  logic [3:0] c_nf;
  logic       w_bad, e_bad, k_bad;
  logic [2:0] k_cls, k_eew, k_emul, k_ieew, k_iemul;
  logic [VL_W-1:0]     k_evl;
  logic [STRIDE_W-1:0] k_stride;

  vls_width_dec u_width (
    .mew(in_mew), .width(in_width), .eew(w_eew), .bad(w_bad)
  );

  vls_emul_calc u_emul (
    .eew(w_eew), .vsew(in_vsew), .vlmul(in_vlmul), .nf(in_nf),
    .lmul_c(c_lmul), .emul(c_emul), .nfields(c_nf), .bad(e_bad)
  );

  vls_class_dec #(.VL_W(VL_W), .STRIDE_W(STRIDE_W), .VLENB(VLENB)) u_class (
    .is_store(in_is_store), .mop(in_mop), .umop(in_umop), .eew(w_eew),
    .emul(c_emul), .nfields(c_nf), .lmul_c(c_lmul), .vsew(in_vsew), .vl(in_vl),
    .cls(k_cls), .o_eew(k_eew), .o_emul(k_emul), .evl(k_evl), .stride(k_stride),
    .idx_eew(k_ieew), .idx_emul(k_iemul), .bad(k_bad)
  );

  logic dec_bad;
  assign dec_bad = w_bad | e_bad | k_bad;

  generate
    if (REG_OUT) begin : g_reg
      logic take;
      assign in_ready = !out_valid || out_ready;
      assign take     = in_valid && in_ready;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         out_valid <= 1'b0;
        else if (take)      out_valid <= 1'b1;
        else if (out_ready) out_valid <= 1'b0;
      end

      always_ff @(posedge clk) begin
        if (take) begin
          out_class    <= k_cls;
          out_eew      <= k_eew;
          out_emul     <= k_emul;
          out_nfields  <= c_nf;
          out_evl      <= k_evl;
          out_stride   <= k_stride;
          out_idx_eew  <= k_ieew;
          out_idx_emul <= k_iemul;
          out_illegal  <= dec_bad;
        end
      end

      // R12: a stalled result must not move
      a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_class) &&
          $stable(out_evl) && $stable(out_illegal) && $stable(out_nfields));
    end else begin : g_comb
      assign in_ready     = out_ready;
      assign out_valid    = in_valid;
      assign out_class    = k_cls;
      assign out_eew      = k_eew;
      assign out_emul     = k_emul;
      assign out_nfields  = c_nf;
      assign out_evl      = k_evl;
      assign out_stride   = k_stride;
      assign out_idx_eew  = k_ieew;
      assign out_idx_emul = k_iemul;
      assign out_illegal  = dec_bad;
    end
  endgenerate

  a_r3_emul_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_illegal |-> out_emul <= 3'd6 && out_idx_emul <= 3'd6);

  a_r4_footprint: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_illegal |->
      (12'(8'd1 << out_idx_emul) * 12'(out_nfields)) <= 12'd64);

  a_r9_whole_pow2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_illegal && out_class == OPC_WHOLE |-> $countones(out_nfields) == 1);

  a_r10_mask_byte: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_illegal && out_class == OPC_MASK |-> out_eew == EW_8);

  a_r11_no_wide_index: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_illegal && (out_class == OPC_IDX_ORD || out_class == OPC_IDX_UNORD)
      |-> out_idx_eew != EW_128);

  a_r13_reset_idle: assert property (@(posedge clk)
    !rst_n |=> !out_valid || $past(rst_n));

endmodule

// File: tb/tb_vls_decoder.sv
`timescale 1ns/1ps
module tb_vls_decoder;
  localparam int VLEN = 128;
  localparam int VL_W = 16;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready, in_is_store = 0, in_mew = 0;
  logic [2:0] in_width = 0, in_nf = 0, in_vsew = 0, in_vlmul = 0;
  logic [1:0] in_mop = 0;
  logic [4:0] in_umop = 0;
  logic [VL_W-1:0] in_vl = 0;
  logic out_valid, out_ready = 1, out_illegal;
  logic [2:0] out_class, out_eew, out_emul, out_idx_eew, out_idx_emul;
  logic [3:0] out_nfields;
  logic [VL_W-1:0] out_evl;
  logic [7:0] out_stride;

  always #2.5 clk = ~clk;

  vls_decoder #(.VLEN(VLEN), .VL_W(VL_W)) dut (.*);

  typedef struct {
    bit ill; int cls, eew, emul, nf, evl, stride, ieew, iemul; string tag;
  } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  function automatic exp_t model(bit st, bit mew, int w, int mop, int um, int nf,
                                 int sew, int lm, int vl, string tag);
    exp_t e; int code, ew, l, em;
    e = '{ill:0, cls:0, eew:0, emul:0, nf:nf+1, evl:vl, stride:0, ieew:0, iemul:0, tag:tag};
    code = (mew ? 8 : 0) + w;
    case (code) 0: ew = 0; 5: ew = 1; 6: ew = 2; 7: ew = 3; 8: ew = 4;
      default: begin e.ill = 1; return e; end endcase
    if (sew >= 4 || lm == 4) begin e.ill = 1; return e; end
    l = (lm < 4) ? lm + 3 : lm - 5;
    em = ew + l - sew;
    if (em < 0 || em > 6 || (1 << em) * (nf + 1) > 64) begin e.ill = 1; return e; end
    e.eew = ew; e.emul = em; e.ieew = ew; e.iemul = em;
    if (mop == 0) begin
      if (um == 0) begin e.cls = 0; e.stride = (1 << ew) * (nf + 1); end
      else if (um == 8) begin
        e.cls = 4; e.evl = (nf + 1) * (VLEN / 8) / (1 << ew);
        if (!(nf == 0 || nf == 1 || nf == 3 || nf == 7) || (st && ew != 0)) e.ill = 1;
      end else if (um == 11) begin
        e.cls = 5; e.evl = (vl + 7) / 8; if (ew != 0) e.ill = 1;
      end else if (um == 16 && !st) e.cls = 6;
      else e.ill = 1;
    end else if (mop == 2) e.cls = 1;
    else begin
      e.cls = (mop == 3) ? 3 : 2; e.eew = sew; e.emul = l;
      if (ew == 4) e.ill = 1;
    end
    return e;
  endfunction

  task automatic send(bit st, bit mew, int w, int mop, int um, int nf,
                      int sew, int lm, int vl, string tag);
    bit acc;
    @(negedge clk);
    in_valid = 1; in_is_store = st; in_mew = mew; in_width = 3'(w); in_mop = 2'(mop);
    in_umop = 5'(um); in_nf = 3'(nf); in_vsew = 3'(sew); in_vlmul = 3'(lm); in_vl = VL_W'(vl);
    do begin
      acc = in_ready;
      if (acc) q.push_back(model(st, mew, w, mop, um, nf, sew, lm, vl, tag));
      @(negedge clk);
    end while (!acc);
    in_valid = 0;
  endtask

  task automatic fail(string tag, string what, int act, int exp);
    errors++;
    $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
  endtask

  // ready pattern changes just after the edge
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 out_ready = !((cyc % 7) == 3 || (cyc % 11) == 5 || (cyc % 13) == 8);
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      exp_t e; bit bad;
      checks++;
      if (q.size() == 0) fail("R12", "unexpected result", 1, 0);
      else begin
        e = q.pop_front(); bad = 0;
        if (out_illegal !== e.ill) begin fail(e.tag, "illegal", out_illegal, e.ill); bad = 1; end
        else if (!e.ill) begin
          if (out_class != e.cls) begin fail(e.tag, "class", out_class, e.cls); bad = 1; end
          if (!bad && out_nfields != e.nf && e.cls != 5) begin fail(e.tag, "nfields", out_nfields, e.nf); bad = 1; end
          if (!bad && out_evl != e.evl) begin fail(e.tag, "evl", out_evl, e.evl); bad = 1; end
          if (!bad && out_eew != e.eew) begin fail(e.tag, "eew", out_eew, e.eew); bad = 1; end
          if (!bad && e.cls != 4 && e.cls != 5 && out_emul != e.emul) begin fail(e.tag, "emul", out_emul, e.emul); bad = 1; end
          if (!bad && e.cls == 0 && out_stride != e.stride) begin fail(e.tag, "stride", out_stride, e.stride); bad = 1; end
          if (!bad && (e.cls == 2 || e.cls == 3) &&
              (out_idx_eew != e.ieew || out_idx_emul != e.iemul))
            fail(e.tag, "index", {out_idx_eew, out_idx_emul}, {e.ieew[2:0], e.iemul[2:0]});
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++; if (out_valid !== 1'b0) fail("R13", "out_valid in reset", out_valid, 0);
    rst_n = 1;
    @(negedge clk);
    checks++; if (in_ready !== 1'b1) fail("R12", "in_ready idle", in_ready, 1);

    send(0,0,6,0,0,0,2,0,10,"R1");       send(0,1,0,0,0,0,3,0,4,"R1");
    send(0,0,5,0,0,2,1,0,3,"R8");
    send(0,0,1,0,0,0,0,0,1,"R2");        send(1,1,3,0,0,0,0,0,1,"R2");
    send(0,0,0,0,0,0,3,5,2,"R3");        send(0,0,7,0,0,0,0,3,2,"R3");
    send(0,0,5,0,0,0,2,7,5,"R3");
    send(0,0,6,0,0,7,2,0,1,"R4");        send(0,0,6,0,0,7,2,1,1,"R4");
    send(1,0,6,0,0,2,2,1,9,"R4");
    send(0,0,0,0,0,0,4,0,1,"R5");        send(0,0,0,0,0,0,0,4,1,"R5");
    send(0,0,6,2,0,0,2,0,7,"R6");        send(1,0,6,1,0,0,2,0,7,"R6");
    send(0,0,6,3,0,0,2,0,7,"R6");
    send(1,0,0,0,16,0,0,0,5,"R7");       send(0,0,0,0,16,0,0,0,5,"R7");
    send(0,0,0,0,1,0,0,0,5,"R7");
    send(0,0,6,0,8,1,2,0,0,"R9");        send(0,0,6,0,8,2,2,0,0,"R9");
    send(1,0,5,0,8,0,1,0,0,"R9");        send(1,0,0,0,8,7,0,0,0,"R9");
    send(0,0,0,0,11,0,0,0,17,"R10");     send(1,0,0,0,11,0,0,0,0,"R10");
    send(0,0,5,0,11,0,1,0,9,"R10");
    send(0,0,5,1,0,0,2,1,6,"R11");       send(1,1,0,3,0,0,3,0,6,"R11");

    for (int st = 0; st < 2; st++)
      for (int wc = 0; wc < 16; wc++)
        for (int mp = 0; mp < 4; mp++)
          for (int ui = 0; ui < 5; ui++)
            for (int ni = 0; ni < 4; ni++)
              for (int s = 0; s < 5; s++)
                for (int lm = 0; lm < 8; lm++) begin
                  int um, nfv;
                  um  = (ui == 0) ? 0 : (ui == 1) ? 8 : (ui == 2) ? 11 : (ui == 3) ? 16 : 3;
                  nfv = (ni == 3) ? 7 : ni;
                  if (mp != 0 && ui != 0) continue;
                  send(st[0], wc[3], wc & 7, mp, um, nfv, s, lm, (wc * 37 + lm * 5 + s) % 300, "R12");
                end

    repeat (20) @(negedge clk);
    checks++; if (q.size() != 0) fail("R12", "results missing", q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule